// File: doc/BRIEF.md
# Ternary Weighted-Logic Level Evaluator

This block computes every output of one level of a three-valued combinational circuit in a single pass. All gates in the level are the same type. Gate j owns ternary digit position j of a result word. Each input variable offers three literals: the value itself, its inversion (2 - x) and its cyclic successor ((x + 1) mod 3). Each literal carries a weight of one bit per digit position, and a set bit means that the gate at that position reads the literal. The level is evaluated by folding all literals, position by position, with the selected operator. The fold starts from 0. A literal whose bit is clear contributes 0, and 0 is the neutral element. No carry ever moves between positions.

The weights and the operator are loaded through a small write port while the datapath is quiet. Input vectors then stream through a valid/ready handshake, and each result is held in an output register until the consumer takes it. MIN and TPROD levels are evaluated through the dual operator: every literal is inverted, the level is folded with MAX or TSUM, and every result digit is inverted.

Top module: `tw_level_eval`

## Requirements
- R1: After reset, out_valid and out_err are 0, in_ready is 1, every weight is zero and the operator is MAX, so the first evaluation returns all-zero digits.
- R2: Ternary digits are coded in two bits: 00 = 0, 01 = 1, 10 = 2. The variable v sits in in_vars[2v+1:2v]. Literal index 3v+0 is the variable, 3v+1 is 2 - x and 3v+2 is (x + 1) mod 3.
- R3: Result digit j is out_digits[2j+1:2j]. Weight bit j of a literal (cfg_wt[j]) selects that literal for digit j, and a clear bit contributes 0 there.
- R4: Operator code 0 (MAX) gives the maximum of the selected literals in each digit.
- R5: Operator code 1 (MODSUM) gives the sum of the selected literals mod 3 in each digit, with no carry into the neighbouring digit.
- R6: Operator code 2 (TSUM) gives min(sum of the selected literals, 2) in each digit.
- R7: Operator code 3 (MIN) gives the minimum of the selected literals in each digit, and gives 2 for a digit that selects no literal.
- R8: Operator code 4 (TPROD) folds the selected literals with max(a + b - 2, 0) in each digit, and gives 2 for a digit that selects no literal.
- R9: Writes with cfg_kind = 1 and an operator code from 5 to 7 are ignored. Writes with cfg_kind = 0 and a literal index of 3*NVAR or more are ignored.
- R10: A configuration write is ignored in any cycle where in_valid or out_valid is high.
- R11: A result is presented with out_valid one clock edge after its handshake (in_valid and in_ready both high). in_ready is high when out_valid is low or out_ready is high, so accepted inputs can stream back to back.
- R12: While out_valid is high and out_ready is low, out_valid, out_digits and out_err hold their values.
- R13: If any variable carries the code 11, that result has out_err = 1 and all digits 0. A legal input that follows clears out_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = write a weight, 1 = write the operator |
| cfg_lit | input | $clog2(3*NVAR) | Literal index for a weight write |
| cfg_wt | input | NDIG | Weight word, one bit per result digit |
| cfg_op | input | 3 | Operator code for an operator write |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can take an input vector |
| in_vars | input | 2*NVAR | Ternary input variables, two bits each |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_digits | output | 2*NDIG | Result digits, two bits each |
| out_err | output | 1 | The result came from an illegal input code |

## Verification
Every result is due on the clock edge that follows its handshake, so the first falling edge after that handshake shows it. A configuration write takes effect on its own edge and therefore shapes only results whose handshake comes later. The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares out_valid, in_ready, the digits and the error flag on every falling edge. The directed checks wait for the handshake edge inside the send task and then read the outputs half a cycle later. The hold cases leave out_ready low across several falling edges to check that nothing moves.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef logic [1:0] trit_t;

  typedef enum logic [2:0] {
    OP_MAX    = 3'd0,
    OP_MODSUM = 3'd1,
    OP_TSUM   = 3'd2,
    OP_MIN    = 3'd3,
    OP_TPROD  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CMB_MAX = 2'd0,
    CMB_MOD = 2'd1,
    CMB_SAT = 2'd2
  } comb_e;

  localparam int FORMS = 3;

  function automatic trit_t t_inv(trit_t a);
    case (a)
      2'd0:    return 2'd2;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic trit_t t_cyc(trit_t a);
    case (a)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic t_bad(trit_t a);
    return a == 2'b11;
  endfunction

  function automatic trit_t t_comb(comb_e k, trit_t a, trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    case (k)
      CMB_MOD: return (s >= 3'd3) ? trit_t'(s - 3'd3) : s[1:0];
      CMB_SAT: return (s > 3'd2) ? 2'd2 : s[1:0];
      default: return (a > b) ? a : b;
    endcase
  endfunction

  function automatic logic op_legal(logic [2:0] c);
    return c <= 3'd4;
  endfunction

endpackage

// File: rtl/tw_literal_gen.sv
module tw_literal_gen
  import tw_pkg::*;
#(
  parameter int NVAR = 2
) (
  input  logic [2*NVAR-1:0]       vars,
  output logic [2*FORMS*NVAR-1:0] lits,
  output logic                    any_bad
);

  logic [NVAR-1:0] bad_v;

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    trit_t x;
    assign x = vars[2*v +: 2];
    assign lits[2*FORMS*v     +: 2] = x;
    assign lits[2*FORMS*v + 2 +: 2] = t_inv(x);
    assign lits[2*FORMS*v + 4 +: 2] = t_cyc(x);
    assign bad_v[v] = t_bad(x);
  end

  assign any_bad = |bad_v;

endmodule

// File: rtl/tw_weight_store.sv
module tw_weight_store #(
  parameter int NLIT = 6,
  parameter int NDIG = 3,
  parameter int LITW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [LITW-1:0]      idx,
  input  logic [NDIG-1:0]      wdata,
  output logic [NLIT*NDIG-1:0] wts
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wts <= '0;
    end else begin
      for (int l = 0; l < NLIT; l++) begin
        if (we && idx == LITW'(l)) begin
          wts[l*NDIG +: NDIG] <= wdata;
        end
      end
    end
  end

endmodule

// File: rtl/tw_digit_reduce.sv
module tw_digit_reduce
  import tw_pkg::*;
#(
  parameter int NLIT = 6,
  parameter int NDIG = 3
) (
  input  logic [2*NLIT-1:0]    lits,
  input  logic [NLIT*NDIG-1:0] wts,
  input  comb_e                kind,
  input  logic                 dual,
  output logic [2*NDIG-1:0]    digits
);

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    trit_t dig_j;

    always_comb begin : p_fold
      trit_t acc;
      trit_t lv;
      acc = '0;
      lv  = '0;
      for (int l = 0; l < NLIT; l++) begin
        lv = lits[2*l +: 2];
        if (dual) lv = t_inv(lv);
        if (!wts[l*NDIG + j]) lv = '0;
        acc = t_comb(kind, acc, lv);
      end
      if (dual) acc = t_inv(acc);
      dig_j = acc;
    end

    assign digits[2*j +: 2] = dig_j;
  end

endmodule

// File: rtl/tw_level_eval.sv
module tw_level_eval
  import tw_pkg::*;
#(
  parameter int NVAR = 2,
  parameter int NDIG = 3,
  localparam int NLIT = FORMS * NVAR,
  localparam int LITW = (NLIT > 1) ? $clog2(NLIT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [LITW-1:0]   cfg_lit,
  input  logic [NDIG-1:0]   cfg_wt,
  input  logic [2:0]        cfg_op,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2*NVAR-1:0] in_vars,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*NDIG-1:0] out_digits,
  output logic              out_err
);

  op_e                 op_q;
  comb_e               kind;
  logic                dual;
  logic                cfg_idle;
  logic                wt_we;
  logic                op_we;
  logic                fire;
  logic                in_bad;
  logic [2*NLIT-1:0]   lits;
  logic [NLIT*NDIG-1:0] wts;
  logic [2*NDIG-1:0]   red;

  assign cfg_idle = !in_valid && !out_valid;
  assign wt_we    = cfg_we && !cfg_kind && cfg_idle && (int'(cfg_lit) < NLIT);
  assign op_we    = cfg_we && cfg_kind && cfg_idle && op_legal(cfg_op);

  always_ff @(posedge clk) begin
    if (rst)        op_q <= OP_MAX;
    else if (op_we) op_q <= op_e'(cfg_op);
  end

  always_comb begin
    case (op_q)
      OP_MODSUM: begin kind = CMB_MOD; dual = 1'b0; end
      OP_TSUM:   begin kind = CMB_SAT; dual = 1'b0; end
      OP_MIN:    begin kind = CMB_MAX; dual = 1'b1; end
      OP_TPROD:  begin kind = CMB_SAT; dual = 1'b1; end
      default:   begin kind = CMB_MAX; dual = 1'b0; end
    endcase
  end

  tw_weight_store #(
    .NLIT (NLIT),
    .NDIG (NDIG),
    .LITW (LITW)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wt_we),
    .idx   (cfg_lit),
    .wdata (cfg_wt),
    .wts   (wts)
  );

  tw_literal_gen #(
    .NVAR (NVAR)
  ) u_lits (
    .vars    (in_vars),
    .lits    (lits),
    .any_bad (in_bad)
  );

  tw_digit_reduce #(
    .NLIT (NLIT),
    .NDIG (NDIG)
  ) u_reduce (
    .lits   (lits),
    .wts    (wts),
    .kind   (kind),
    .dual   (dual),
    .digits (red)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_digits <= '0;
      out_err    <= 1'b0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_digits <= in_bad ? '0 : red;
      out_err    <= in_bad;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/tw_level_eval_chk.sv
module tw_level_eval_chk #(
  parameter int NDIG = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*NDIG-1:0] out_digits,
  input logic              out_err
);

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    a_r3_digit_legal: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_digits[2*j +: 2] != 2'b11);
  end

  a_r11_result_next: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r11_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_digits) && $stable(out_err));

  a_r13_err_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_digits == '0);

endmodule

bind tw_level_eval tw_level_eval_chk #(.NDIG(NDIG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_digits (out_digits),
  .out_err    (out_err)
);

// File: tb/test_tw_level_eval.sv
`timescale 1ns/1ps
module test_tw_level_eval;

  localparam int NV = 2;
  localparam int ND = 3;
  localparam int NL = 3 * NV;
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we, cfg_kind;
  logic [LW-1:0] cfg_lit;
  logic [ND-1:0] cfg_wt;
  logic [2:0]    cfg_op;
  logic          in_valid, in_ready, out_valid, out_ready, out_err;
  logic [2*NV-1:0] in_vars;
  logic [2*ND-1:0] out_digits;

  always #10 clk = ~clk;

  tw_level_eval #(.NVAR(NV), .NDIG(ND)) i_tw_level_eval (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_lit(cfg_lit), .cfg_wt(cfg_wt), .cfg_op(cfg_op),
    .in_valid(in_valid), .in_ready(in_ready), .in_vars(in_vars),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_digits(out_digits), .out_err(out_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_w[NL];
  int m_op;
  bit m_valid;
  int m_dig;
  bit m_err;

  function automatic void ref_eval(input logic [2*NV-1:0] v, output int dig, output bit err);
    int x[NV];
    err = 0;
    dig = 0;
    for (int i = 0; i < NV; i++) begin
      x[i] = int'(v[2*i +: 2]);
      if (x[i] == 3) err = 1;
    end
    if (err) return;
    for (int j = 0; j < ND; j++) begin
      int acc = 0;
      for (int l = 0; l < NL; l++) begin
        int b = x[l/3];
        int val = (l % 3 == 0) ? b : ((l % 3 == 1) ? 2 - b : (b + 1) % 3);
        if (m_op >= 3) val = 2 - val;
        if (((m_w[l] >> j) & 1) == 0) val = 0;
        case (m_op)
          1:       acc = (acc + val) % 3;
          2, 4:    acc = (acc + val > 2) ? 2 : acc + val;
          default: acc = (val > acc) ? val : acc;
        endcase
      end
      if (m_op >= 3) acc = 2 - acc;
      dig += acc << (2 * j);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int l = 0; l < NL; l++) m_w[l] = 0;
      m_op = 0; m_valid = 0; m_dig = 0; m_err = 0;
    end else begin
      if (cfg_we && !in_valid && !m_valid) begin
        if (cfg_kind && cfg_op <= 4) m_op = int'(cfg_op);
        if (!cfg_kind && int'(cfg_lit) < NL) m_w[cfg_lit] = int'(cfg_wt);
      end
      if (in_valid && (!m_valid || out_ready)) begin
        ref_eval(in_vars, m_dig, m_err);
        m_valid = 1;
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 out_valid vs model", int'(out_valid), int'(m_valid));
      chk("R11 in_ready vs model", int'(in_ready), int'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R3 digits vs model", int'(out_digits), m_dig);
        chk("R13 err vs model", int'(out_err), int'(m_err));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [2*NV-1:0] pk(int a, int b);
    return {b[1:0], a[1:0]};
  endfunction

  function automatic int dg(int d0, int d1, int d2);
    return d2 * 16 + d1 * 4 + d0;
  endfunction

  task automatic setw(int l, logic [ND-1:0] w);
    @(negedge clk); #1;
    cfg_we = 1; cfg_kind = 0; cfg_lit = LW'(l); cfg_wt = w;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic setop(int op);
    @(negedge clk); #1;
    cfg_we = 1; cfg_kind = 1; cfg_op = op[2:0];
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(logic [2*NV-1:0] v);
    logic r;
    @(negedge clk); #1;
    in_valid = 1; in_vars = v;
    forever begin
      r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    in_valid = 0;
  endtask

  task automatic chk_out(string req, int exp_dig, int exp_err);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " digits"}, int'(out_digits), exp_dig);
    chk({req, " err"}, int'(out_err), exp_err);
  endtask

  initial begin
    rst = 1; cfg_we = 0; cfg_kind = 0; cfg_lit = '0; cfg_wt = '0; cfg_op = '0;
    in_valid = 0; in_vars = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_err in reset", int'(out_err), 0);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    send(pk(2, 2));
    chk_out("R1 zero weights", 0, 0);

    // R4 R3: three MAX gates with mixed literals
    setw(0, 3'b101); setw(3, 3'b011); setw(1, 3'b010); setw(4, 3'b100);
    send(pk(0, 0)); chk_out("R4 level 00", dg(0, 2, 2), 0);
    send(pk(1, 2)); chk_out("R3 level 12", dg(2, 2, 1), 0);

    setw(1, 3'b000); setw(4, 3'b000); setw(3, 3'b110);
    send(pk(2, 1)); chk_out("R4 max", dg(2, 1, 2), 0);
    setop(1);
    send(pk(2, 2)); chk_out("R5 modsum no carry", dg(2, 2, 1), 0);
    send(pk(1, 1)); chk_out("R5 modsum", dg(1, 1, 2), 0);
    setop(2);
    send(pk(2, 1)); chk_out("R6 tsum sat", dg(2, 1, 2), 0);
    send(pk(1, 1)); chk_out("R6 tsum", dg(1, 1, 2), 0);
    send(pk(1, 0)); chk_out("R6 tsum zero", dg(1, 0, 1), 0);
    setop(3);
    send(pk(2, 1)); chk_out("R7 min", dg(2, 1, 1), 0);
    send(pk(0, 2)); chk_out("R7 min low", dg(0, 2, 0), 0);
    setw(0, 3'b001); setw(3, 3'b010);
    send(pk(0, 1)); chk_out("R7 empty digit", dg(0, 1, 2), 0);
    setop(4); setw(0, 3'b101); setw(3, 3'b110);
    send(pk(2, 1)); chk_out("R8 tprod", dg(2, 1, 1), 0);
    send(pk(1, 1)); chk_out("R8 tprod floor", dg(1, 1, 0), 0);
    send(pk(2, 2)); chk_out("R8 tprod top", dg(2, 2, 2), 0);

    // R2 literal forms
    setop(0); setw(0, 3'b000); setw(3, 3'b000);
    setw(2, 3'b001); setw(1, 3'b010); setw(5, 3'b100);
    send(pk(0, 2)); chk_out("R2 forms 02", dg(1, 2, 0), 0);
    send(pk(2, 1)); chk_out("R2 forms 21", dg(0, 0, 2), 0);

    // R9 illegal codes and indices
    setw(1, 3'b000); setw(2, 3'b000); setw(5, 3'b000);
    setw(0, 3'b101); setw(3, 3'b110); setop(1);
    setop(7); setop(5); setw(6, 3'b111); setw(7, 3'b111);
    send(pk(2, 2)); chk_out("R9 ignored writes", dg(2, 2, 1), 0);

    // R12 hold and R10 blocked writes
    @(negedge clk); #1 out_ready = 0;
    send(pk(2, 2)); chk_out("R12 held result", dg(2, 2, 1), 0);
    in_valid = 1; in_vars = pk(1, 1);
    cfg_we = 1; cfg_kind = 0; cfg_lit = '0; cfg_wt = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_out("R12 stall", dg(2, 2, 1), 0);
      chk("R12 in_ready low", int'(in_ready), 0);
    end
    #1 in_valid = 0; cfg_kind = 1; cfg_op = 3'd0;
    @(negedge clk); #1;
    cfg_we = 0; out_ready = 1;
    @(negedge clk);
    chk("R11 drained", int'(out_valid), 0);
    send(pk(2, 2)); chk_out("R10 writes blocked", dg(2, 2, 1), 0);

    // R11 back-to-back stream
    @(negedge clk); #1;
    in_valid = 1; in_vars = pk(1, 1);
    @(negedge clk);
    chk_out("R11 stream first", dg(1, 1, 2), 0);
    #1 in_vars = pk(2, 1);
    @(negedge clk);
    chk_out("R11 stream second", dg(2, 1, 0), 0);
    #1 in_valid = 0;

    // R13 illegal code
    send(4'b1100); chk_out("R13 illegal", 0, 1);
    send(pk(1, 1)); chk_out("R13 recover", dg(1, 1, 2), 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule